// File: doc/BRIEF.md
# Register-Programmed AHB-Lite Master Bridge

This block gives a host a small register port through which it can run word-sized read and write bursts on an internal AHB-Lite bus. The bridge is the only master on that bus. The host first stages the work. For a write, it pushes the payload one word at a time into a data-input register that feeds a write FIFO. It then programs a control register with the word count and the direction.

Writing the full starting bus address into the address register launches the transfer; there is no separate start bit. The bridge issues one single-word transfer per beat and steps the address by 4 after each accepted beat. On a read, every returned word lands in a read FIFO, and the host drains it through a data-output register.

The host port has no back-pressure signal. The host paces itself by reading the FIFO levels in the status register. A push to a full write FIFO is lost, and a pop of an empty read FIFO returns zero. On the bus side the bridge obeys HREADY as a wait state, and it stops a transfer on an ERROR response.

Top module: `ahbbr_top`

## Requirements
- R1: Host register offsets are as follows. 0x00 is the write-only data input; a write pushes one word, and the word is dropped when the write FIFO already holds 8. 0x0C is the read-only data output; a read pops one word, and returns 0 with nothing popped when the read FIFO is empty. Read data appears on `hst_rdata` in the cycle after `hst_ren`.
- R2: Control at offset 0x04 holds the length in bits [3:0] and the direction in bit 8 (1 = write, 0 = read). Reading it returns exactly those fields, with all other bits zero.
- R3: A write to offset 0x08 while idle starts a transfer at that unchanged 32-bit address. Each beat is a single transfer with HTRANS NONSEQ (2'b10), HSIZE word (3'b010) and HBURST single. Beat k uses address start + 4*k, and HTRANS is IDLE (2'b00) between beats.
- R4: While HREADY is low during an address phase, HTRANS, HADDR and HWRITE stay unchanged.
- R5: During a read transfer, each completed beat pushes HRDATA into the read FIFO in bus order.
- R6: An ERROR response (HRESP high with HREADY high) ends the transfer and clears busy. It sets the sticky error flag in status bit 2, which stays set until the host writes 1 to bit 2 at offset 0x10. The failed beat consumes no write-FIFO word.
- R7: A write transfer issues no beat, and keeps HTRANS IDLE, until the write FIFO holds at least the programmed length. A read transfer likewise waits until the read FIFO has that much free space.
- R8: A length of 0 starts no bus activity and sets done immediately. A length above 8 is treated as 8.
- R9: Status at offset 0x10 is laid out as follows: bit 0 busy, bit 1 done, bit 2 error, bits [11:8] write-FIFO level, bits [19:16] read-FIFO level. A write to offset 0x08 while busy is ignored.
- R10: Done is set when the last beat completes and is cleared when the next transfer is launched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_addr | input | 5 | Host register byte offset |
| hst_wen | input | 1 | Host register write strobe |
| hst_wdata | input | 32 | Host write data |
| hst_ren | input | 1 | Host register read strobe |
| hst_rdata | output | 32 | Host read data, one cycle after the strobe |
| haddr | output | 32 | AHB address |
| htrans | output | 2 | AHB transfer type |
| hsize | output | 3 | AHB transfer size |
| hburst | output | 3 | AHB burst type, always single |
| hwrite | output | 1 | AHB write direction |
| hwdata | output | 32 | AHB write data |
| hrdata | input | 32 | AHB read data |
| hready | input | 1 | AHB transfer done / wait state when low |
| hresp | input | 1 | AHB error response |

## Verification
The bench builds the bridge with its default parameters: 32-bit data and address, and 8-word FIFOs with a 4-bit length field. These values bring a full 8-word burst within reach, along with the clamp of a programmed length of 15 down to 8 and the loss of a ninth push into a full write FIFO. A bus slave model in the bench adds 0 to 3 wait states per beat and answers one address with a two-cycle ERROR. This exercises the wait-state hold, the sticky error flag, and the words left behind in the write FIFO after an aborted burst.

// File: rtl/ahbbr_pkg.sv
package ahbbr_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_HOLD, SQ_ADDR, SQ_DATA} sq_state_e;

  localparam logic [1:0] HT_IDLE   = 2'b00;
  localparam logic [1:0] HT_NONSEQ = 2'b10;
  localparam logic [2:0] HS_WORD   = 3'b010;
  localparam logic [2:0] HB_SINGLE = 3'b000;

  localparam logic [4:0] OFS_DIN  = 5'h00;
  localparam logic [4:0] OFS_CTRL = 5'h04;
  localparam logic [4:0] OFS_ADDR = 5'h08;
  localparam logic [4:0] OFS_DOUT = 5'h0C;
  localparam logic [4:0] OFS_STAT = 5'h10;
endpackage

// File: rtl/ahbbr_fifo.sv
module ahbbr_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  assign do_push = push && (cnt != LW'(DEPTH));
  assign do_pop  = pop && (cnt != '0);

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      cnt <= cnt + LW'(do_push) - LW'(do_pop);
    end
  end

  assign head  = mem[rd_ptr];
  assign level = cnt;

  // R1
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LW'(DEPTH));
endmodule

// File: rtl/ahbbr_seq.sv
module ahbbr_seq
  import ahbbr_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] start_len,
  input  logic          start_wr,
  input  logic [LW-1:0] wr_level,
  input  logic [LW-1:0] rd_free,
  input  logic [DW-1:0] wr_head,
  input  logic          hready,
  input  logic          hresp,
  input  logic [DW-1:0] hrdata,
  output logic [AW-1:0] haddr,
  output logic [1:0]    htrans,
  output logic          hwrite,
  output logic [DW-1:0] hwdata,
  output logic          wf_pop,
  output logic          rf_push,
  output logic [DW-1:0] rf_data,
  output logic          busy,
  output logic          fin,
  output logic          fault
);
  sq_state_e     st;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] left_q;
  logic          wr_q;
  logic          room, beat_ok;

  assign room    = wr_q ? (wr_level >= left_q) : (rd_free >= left_q);
  assign beat_ok = (st == SQ_DATA) && hready && !hresp;
  assign fault   = (st == SQ_DATA) && hready && hresp;
  assign fin     = beat_ok && (left_q == LW'(1));
  assign wf_pop  = beat_ok && wr_q;
  assign rf_push = beat_ok && !wr_q;
  assign rf_data = hrdata;
  assign busy    = (st != SQ_IDLE);
  assign haddr   = addr_q;
  assign htrans  = (st == SQ_ADDR) ? HT_NONSEQ : HT_IDLE;
  assign hwrite  = wr_q;
  assign hwdata  = wr_head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SQ_IDLE;
      addr_q <= '0;
      left_q <= '0;
      wr_q   <= 1'b0;
    end else begin
      unique case (st)
        SQ_IDLE: if (start) begin
          addr_q <= start_addr;
          left_q <= start_len;
          wr_q   <= start_wr;
          st     <= SQ_HOLD;
        end
        SQ_HOLD: if (room) st <= SQ_ADDR;
        SQ_ADDR: if (hready) st <= SQ_DATA;
        SQ_DATA: if (fault || fin) begin
          st <= SQ_IDLE;
        end else if (beat_ok) begin
          left_q <= left_q - 1'b1;
          addr_q <= addr_q + AW'(4);
          st     <= SQ_ADDR;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == HT_NONSEQ && !hready) |=>
      (htrans == HT_NONSEQ && $stable(haddr) && $stable(hwrite)));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ok && !fin) |=> (haddr == $past(haddr) + AW'(4)));

  // R7
  wr_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == HT_NONSEQ && hwrite) |-> (wr_level != '0));

  // R6
  fault_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !busy);
endmodule

// File: rtl/ahbbr_top.sv
module ahbbr_top
  import ahbbr_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    hst_addr,
  input  logic          hst_wen,
  input  logic [DW-1:0] hst_wdata,
  input  logic          hst_ren,
  output logic [DW-1:0] hst_rdata,
  output logic [AW-1:0] haddr,
  output logic [1:0]    htrans,
  output logic [2:0]    hsize,
  output logic [2:0]    hburst,
  output logic          hwrite,
  output logic [DW-1:0] hwdata,
  input  logic [DW-1:0] hrdata,
  input  logic          hready,
  input  logic          hresp
);
  logic [LW-1:0] len_q, len_eff, wlvl, rlvl, rfree;
  logic          dir_q, done_q, err_q;
  logic [DW-1:0] wf_head, rf_head, rf_data, stat, ctrl_rd;
  logic          wf_push, wf_pop, rf_push, rf_pop;
  logic          busy, fin, fault, launch, seq_start;

  assign len_eff   = (len_q > LW'(DEPTH)) ? LW'(DEPTH) : len_q;
  assign rfree     = LW'(DEPTH) - rlvl;
  assign wf_push   = hst_wen && (hst_addr == OFS_DIN);
  assign rf_pop    = hst_ren && (hst_addr == OFS_DOUT);
  assign launch    = hst_wen && (hst_addr == OFS_ADDR) && !busy;
  assign seq_start = launch && (len_eff != '0);
  assign hsize     = HS_WORD;
  assign hburst    = HB_SINGLE;

  ahbbr_fifo #(.W(DW), .DEPTH(DEPTH)) i_wfifo (
    .clk, .rst_n, .push(wf_push), .din(hst_wdata), .pop(wf_pop),
    .head(wf_head), .level(wlvl));

  ahbbr_fifo #(.W(DW), .DEPTH(DEPTH)) i_rfifo (
    .clk, .rst_n, .push(rf_push), .din(rf_data), .pop(rf_pop),
    .head(rf_head), .level(rlvl));

  ahbbr_seq #(.AW(AW), .DW(DW), .LW(LW)) i_seq (
    .clk, .rst_n, .start(seq_start), .start_addr(hst_wdata[AW-1:0]),
    .start_len(len_eff), .start_wr(dir_q), .wr_level(wlvl), .rd_free(rfree),
    .wr_head(wf_head), .hready, .hresp, .hrdata, .haddr, .htrans, .hwrite,
    .hwdata, .wf_pop, .rf_push, .rf_data, .busy, .fin, .fault);

  always_comb begin
    stat = '0;
    stat[0] = busy;
    stat[1] = done_q;
    stat[2] = err_q;
    stat[8 +: LW]  = wlvl;
    stat[16 +: LW] = rlvl;
    ctrl_rd = '0;
    ctrl_rd[LW-1:0] = len_q;
    ctrl_rd[8] = dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q     <= '0;
      dir_q     <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      hst_rdata <= '0;
    end else begin
      if (hst_wen && hst_addr == OFS_CTRL) begin
        len_q <= hst_wdata[LW-1:0];
        dir_q <= hst_wdata[8];
      end
      if (launch)   done_q <= (len_eff == '0);
      else if (fin) done_q <= 1'b1;
      if (fault) err_q <= 1'b1;
      else if (hst_wen && hst_addr == OFS_STAT && hst_wdata[2]) err_q <= 1'b0;
      if (hst_ren) begin
        unique case (hst_addr)
          OFS_CTRL: hst_rdata <= ctrl_rd;
          OFS_DOUT: hst_rdata <= (rlvl != '0) ? rf_head : '0;
          OFS_STAT: hst_rdata <= stat;
          default:  hst_rdata <= '0;
        endcase
      end
    end
  end

  // R8
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && len_eff == '0) |=> (done_q && !busy));

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wen && hst_addr == OFS_ADDR && busy && !fin && !fault) |=> busy);
endmodule

// File: tb/test_ahbbr_top.sv
module test_ahbbr_top;
  import ahbbr_pkg::*;

  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam logic [4:0]  ERR_IDX = 5'd30;
  // {dir at [24], len at [19:16], word index at [15:8], wait states at [7:0]}
  localparam logic [31:0] VEC [6] = '{
    32'h0101_0000, 32'h0104_0402, 32'h0004_0401,
    32'h0108_1000, 32'h0008_1003, 32'h0002_0000};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] hst_addr = '0;
  logic hst_wen = 1'b0, hst_ren = 1'b0;
  logic [31:0] hst_wdata = '0, hst_rdata;
  logic [31:0] haddr, hwdata, hrdata;
  logic [1:0] htrans;
  logic [2:0] hsize, hburst;
  logic hwrite, hready, hresp;

  int total = 0, bad = 0, aphases = 0, addr_bad = 0;
  bit finished = 1'b0;
  logic [31:0] smem [32];
  logic [31:0] exp_mem [32];
  logic [7:0] slv_waits = '0;
  logic err_en = 1'b0;

  always #10 clk = ~clk;

  ahbbr_top i_ahbbr_top (.clk, .rst_n, .hst_addr, .hst_wen, .hst_wdata,
    .hst_ren, .hst_rdata, .haddr, .htrans, .hsize, .hburst, .hwrite, .hwdata,
    .hrdata, .hready, .hresp);

  // bus slave model
  logic dp_act, dp_wr, dp_err;
  logic [4:0] dp_idx;
  logic [7:0] wcnt;
  assign hready = !dp_act || (wcnt == 0);
  assign hresp  = dp_act && dp_err && (wcnt <= 1);
  assign hrdata = dp_act ? smem[dp_idx] : 32'h0;

  always @(posedge clk) begin
    if (!rst_n) begin
      dp_act <= 1'b0; dp_wr <= 1'b0; dp_err <= 1'b0; dp_idx <= '0; wcnt <= '0;
      for (int i = 0; i < 32; i++) smem[i] <= '0;
    end else begin
      if (dp_act && hready) begin
        if (dp_wr && !dp_err) smem[dp_idx] <= hwdata;
        dp_act <= 1'b0;
      end else if (dp_act && wcnt != 0) wcnt <= wcnt - 1'b1;
      if (hready && htrans == HT_NONSEQ) begin
        aphases <= aphases + 1;
        if (haddr[31:7] != BASE[31:7] || hsize != HS_WORD || haddr[1:0] != 2'b00)
          addr_bad <= addr_bad + 1;
        dp_act <= 1'b1;
        dp_wr  <= hwrite;
        dp_idx <= haddr[6:2];
        dp_err <= err_en && haddr[6:2] == ERR_IDX;
        wcnt   <= (err_en && haddr[6:2] == ERR_IDX && slv_waits == 0) ? 8'd1 : slv_waits;
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic hw(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); hst_addr = a; hst_wdata = d; hst_wen = 1'b1;
    @(negedge clk); hst_wen = 1'b0;
  endtask

  task automatic hr(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); hst_addr = a; hst_ren = 1'b1;
    @(negedge clk); hst_ren = 1'b0; d = hst_rdata;
  endtask

  task automatic wait_idle(output logic [31:0] s);
    for (int i = 0; i < 400; i++) begin
      hr(OFS_STAT, s);
      if (!s[0]) break;
    end
  endtask

  logic [31:0] rd, st;
  int n0;

  initial begin
    for (int i = 0; i < 32; i++) exp_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    hr(OFS_STAT, st); chk(st, 32'h0, "R9 reset status");
    chk({30'h0, htrans}, 32'h0, "R3 reset htrans idle");
    hr(OFS_DOUT, rd); chk(rd, 32'h0, "R1 empty read returns 0");

    // vector table
    for (int v = 0; v < 6; v++) begin
      automatic logic dir = VEC[v][24];
      automatic int len = int'(VEC[v][19:16]);
      automatic int idx = int'(VEC[v][15:8]);
      slv_waits = VEC[v][7:0];
      if (dir) for (int k = 0; k < len; k++) begin
        hw(OFS_DIN, 32'h1000_0000 * (v + 1) + k);
        exp_mem[idx + k] = 32'h1000_0000 * (v + 1) + k;
      end
      hw(OFS_CTRL, {23'h0, dir, 4'h0, VEC[v][19:16]});
      hw(OFS_ADDR, BASE + 32'(idx * 4));
      wait_idle(st);
      chk(st, 32'h2 | (dir ? 32'h0 : 32'(len) << 16), "R10 done and levels after vector");
      for (int k = 0; k < len; k++) begin
        if (dir) chk(smem[idx + k], exp_mem[idx + k], "R3 written word");
        else begin
          hr(OFS_DOUT, rd); chk(rd, exp_mem[idx + k], "R5 read word order");
        end
      end
    end
    slv_waits = 8'd0;

    // control readback
    hw(OFS_CTRL, 32'hFFFF_F1F5);
    hr(OFS_CTRL, rd); chk(rd, 32'h0000_0105, "R2 control readback");

    // full write FIFO drops ninth word, length 15 clamps to 8
    for (int k = 0; k < 9; k++) hw(OFS_DIN, 32'hD0 + k);
    hr(OFS_STAT, st); chk(st, 32'h802, "R1 write FIFO saturates at 8");
    hw(OFS_CTRL, 32'h10F);
    hw(OFS_ADDR, BASE + 32'd32);
    wait_idle(st); chk(st, 32'h2, "R8 clamped burst drains FIFO");
    for (int k = 0; k < 8; k++) begin
      chk(smem[8 + k], 32'hD0 + k, "R8 clamped burst data");
      exp_mem[8 + k] = 32'hD0 + k;
    end

    // error response
    err_en = 1'b1;
    for (int k = 0; k < 3; k++) hw(OFS_DIN, 32'hE0 + k);
    hw(OFS_CTRL, 32'h103);
    hw(OFS_ADDR, BASE + 32'd116);
    wait_idle(st); chk(st, 32'h204, "R6 error sticky, busy clear");
    chk(smem[29], 32'hE0, "R6 beat before error written");
    chk(smem[31], 32'h0, "R6 no beat after error");
    hw(OFS_STAT, 32'h2);
    hr(OFS_STAT, st); chk(st, 32'h204, "R6 error kept without bit 2");
    hw(OFS_STAT, 32'h4);
    hr(OFS_STAT, st); chk(st, 32'h200, "R6 error cleared by write 1");
    err_en = 1'b0;

    // zero length
    n0 = aphases;
    hw(OFS_CTRL, 32'h100);
    hw(OFS_ADDR, BASE);
    hr(OFS_STAT, st); chk(st, 32'h202, "R8 zero length sets done");
    chk(32'(aphases - n0), 32'h0, "R8 zero length no bus beat");

    // drain leftovers after error
    hw(OFS_CTRL, 32'h102);
    hw(OFS_ADDR, BASE + 32'd96);
    wait_idle(st); chk(st, 32'h2, "R6 leftover words drained");
    chk(smem[24], 32'hE1, "R6 leftover word 1");
    chk(smem[25], 32'hE2, "R6 leftover word 2");

    // write stall
    hw(OFS_CTRL, 32'h103);
    hw(OFS_DIN, 32'hF0);
    hw(OFS_ADDR, BASE + 32'd80);
    repeat (10) @(negedge clk);
    chk({30'h0, htrans}, 32'h0, "R7 stalled write keeps htrans idle");
    hr(OFS_STAT, st); chk(st, 32'h101, "R7 stalled write busy level 1");
    hw(OFS_DIN, 32'hF1); hw(OFS_DIN, 32'hF2);
    wait_idle(st); chk(st, 32'h2, "R7 stalled write completes");
    for (int k = 0; k < 3; k++) chk(smem[20 + k], 32'hF0 + k, "R7 stalled write data");

    // start while busy is ignored, done cleared at launch
    slv_waits = 8'd3;
    for (int k = 0; k < 8; k++) hw(OFS_DIN, 32'hB0 + k);
    hw(OFS_CTRL, 32'h108);
    n0 = aphases;
    hw(OFS_ADDR, BASE + 32'd32);
    hw(OFS_ADDR, BASE);
    hr(OFS_STAT, st); chk(st & 32'h7, 32'h1, "R10 done cleared at launch, R9 busy");
    wait_idle(st); chk(st, 32'h2, "R10 done after burst");
    chk(32'(aphases - n0), 32'd8, "R9 second start ignored");
    chk(smem[0], exp_mem[0], "R9 ignored address untouched");
    for (int k = 0; k < 8; k++) chk(smem[8 + k], 32'hB0 + k, "R4 waited write data");
    chk(32'(addr_bad), 32'h0, "R3 address and size seen by bus");

    $display("test done: total=%0d bad=%0d", total, bad);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule